// File: doc/BRIEF.md
# Register-Cached Circular Operand Stack

This block is the operand stack of a stack-machine core. Its two topmost words sit in registers, so an ALU reads both operands straight from the outputs with no added latency. Deeper words are spilled into a small single-port circular array that is addressed by a wrapping pointer. There is no overflow or underflow detection. If the stack grows past its capacity, the oldest spilled words are overwritten. Popping past the bottom simply wraps around and returns whatever the array holds.

An external controller drives one command per cycle on a 3-bit code together with a data word. The commands are push, pop, replace-top and a binary-operation retire. The binary-operation retire removes two operands and leaves one result. This command reserves the array's single port for one further cycle and raises `busy_o` during that cycle. The controller must hold off while `busy_o` is high, and any command presented during that cycle is dropped.

Top module: `cached_opstack`

## Requirements
- R1: After reset, `tos_o`, `nos_o` and `busy_o` are all zero and the array pointer is at slot 0.
- R2: Command codes are 0 = idle, 1 = push, 2 = pop, 3 = replace-top and 4 = binary-op. Codes 5, 6 and 7 behave exactly like idle. An idle cycle leaves the top word, the next word and the depth unchanged.
- R3: Push makes `tos_o` the data word and `nos_o` the previous top. The previous next word is stored in the array at the incremented pointer. All of this completes in one cycle.
- R4: Pop makes `tos_o` the previous next word. `nos_o` is refilled from the array slot at the current pointer, and then the pointer decrements.
- R5: Replace-top writes the data word into `tos_o`. It leaves `nos_o` and the stack depth unchanged.
- R6: Binary-op writes the data word (the ALU result) into `tos_o` and refills `nos_o` from the array, leaving the stack one word shallower. `busy_o` is high during the following cycle.
- R7: `busy_o` stays high for exactly one cycle. A command presented while it is high has no effect on `tos_o`, `nos_o` or the depth.
- R8: The array has 8 slots behind the two registers, and the pointer wraps modulo 8. A push sequence longer than 10 overwrites the oldest words. Pops beyond the bottom wrap round through the array.
- R9: Over any mix of commands, the words returned follow last-in-first-out order within the capacity limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code (see R2) |
| wdata_i | input | 32 | Push value, replacement value or ALU result |
| tos_o | output | 32 | Top of stack |
| nos_o | output | 32 | Next of stack |
| busy_o | output | 1 | Wait cycle after a binary-op; commands ignored |

## Verification
The bench builds the stack with its default parameters: a 32-bit word and an 8-slot array. With these values, 12 consecutive pushes overrun the 10-word capacity and force the pointer through a full wrap. The pops that follow walk back past slot 0. This exercises the overwrite and wrap behaviour of R8 within a few dozen cycles. A bench-side model of the register pair and the array is compared after every command. The model tracks which array slots hold defined data, so words that were never written are not compared.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_PUSH = 3'd1,
    CMD_POP  = 3'd2,
    CMD_REPL = 3'd3,
    CMD_BIN  = 3'd4
  } cmd_e;

  // Step a pointer one slot up or down, wrapping modulo the depth.
  function automatic int unsigned wrap_step(input int unsigned cur,
                                            input int unsigned depth,
                                            input bit          up);
    int unsigned r;
    if (up) r = (cur + 1 >= depth) ? 0 : cur + 1;
    else    r = (cur == 0) ? depth - 1 : cur - 1;
    return r;
  endfunction

endpackage

// File: rtl/opstack_ram.sv
module opstack_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = we && (addr == AW'(g));
    always_ff @(posedge clk) begin
      if (slot_we[g]) slot_q[g] <= wdata;
    end
  end

  // Single shared address: asynchronous read of the addressed slot.
  assign rdata = slot_q[addr];

  AST_ONE_SLOT_WRITE: assert property (@(posedge clk) $onehot0(slot_we)); // R3

endmodule

// File: rtl/opstack_ptr.sv
module opstack_ptr
  import opstack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] ptr_up_o
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_dn;

  assign ptr_up_o = AW'(wrap_step(int'(ptr_q), DEPTH, 1'b1));
  assign ptr_dn   = AW'(wrap_step(int'(ptr_q), DEPTH, 1'b0));
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (inc) ptr_q <= ptr_up_o;
    else if (dec) ptr_q <= ptr_dn;
  end

  AST_PTR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec)); // R2
  AST_PTR_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc && ($past(ptr_q) == AW'(DEPTH-1) || ptr_q == AW'(DEPTH-1)) |=>
      (ptr_q == (($past(ptr_q) == AW'(DEPTH-1)) ? '0 : $past(ptr_q) + 1'b1))); // R8
  AST_PTR_DEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec && ptr_q == '0 |=> ptr_q == AW'(DEPTH-1)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !dec |=> $stable(ptr_q)); // R2

endmodule

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
  import opstack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_i,
  output logic       do_push,
  output logic       do_pop,
  output logic       do_repl,
  output logic       do_bin,
  output logic       busy_o
);

  logic busy_q;
  logic accept;

  assign accept  = !busy_q;
  assign do_push = accept && (cmd_i == CMD_PUSH);
  assign do_pop  = accept && (cmd_i == CMD_POP);
  assign do_repl = accept && (cmd_i == CMD_REPL);
  assign do_bin  = accept && (cmd_i == CMD_BIN);
  assign busy_o  = busy_q;

  // Wait state: the array port stays reserved for one cycle after a binary-op.
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= do_bin;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_push, do_pop, do_repl, do_bin})); // R2
  AST_BIN_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    do_bin |=> busy_o); // R6
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(do_push || do_pop || do_repl || do_bin)); // R7

endmodule

// File: rtl/cached_opstack.sv
module cached_opstack
  import opstack_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] tos_o,
  output logic [WIDTH-1:0] nos_o,
  output logic             busy_o
);

  logic             do_push, do_pop, do_repl, do_bin;
  logic             refill;
  logic [AW-1:0]    ptr_cur, ptr_up, ram_addr;
  logic [WIDTH-1:0] ram_rdata;
  logic [WIDTH-1:0] tos_q, nos_q;

  opstack_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_i   (cmd_i),
    .do_push (do_push),
    .do_pop  (do_pop),
    .do_repl (do_repl),
    .do_bin  (do_bin),
    .busy_o  (busy_o)
  );

  assign refill = do_pop || do_bin;

  opstack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (do_push),
    .dec      (refill),
    .ptr_o    (ptr_cur),
    .ptr_up_o (ptr_up)
  );

  // One port: a spill writes above the pointer, a refill reads at it.
  assign ram_addr = do_push ? ptr_up : ptr_cur;

  opstack_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (do_push),
    .addr  (ram_addr),
    .wdata (nos_q),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos_q <= '0;
      nos_q <= '0;
    end else if (do_push) begin
      tos_q <= wdata_i;
      nos_q <= tos_q;
    end else if (refill) begin
      tos_q <= do_bin ? wdata_i : nos_q;
      nos_q <= ram_rdata;
    end else if (do_repl) begin
      tos_q <= wdata_i;
    end
  end

  assign tos_o = tos_q;
  assign nos_o = nos_q;

  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> tos_o == $past(wdata_i) && nos_o == $past(tos_o)); // R3
  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> tos_o == $past(nos_o)); // R4
  AST_REPL_KEEP_NOS: assert property (@(posedge clk) disable iff (!rst_n)
    do_repl |=> tos_o == $past(wdata_i) && $stable(nos_o)); // R5
  AST_BIN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    do_bin |=> tos_o == $past(wdata_i)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_push || do_pop || do_repl || do_bin) |=> $stable(tos_o) && $stable(nos_o)); // R7

endmodule

// File: tb/cached_opstack_tb.sv
module cached_opstack_tb;

  localparam int W = 32;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cmd_i = 3'd0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] tos_o, nos_o;
  logic         busy_o;

  always #10 clk = ~clk;

  cached_opstack #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .wdata_i(wdata_i),
    .tos_o(tos_o), .nos_o(nos_o), .busy_o(busy_o)
  );

  int errors = 0;
  int checks = 0;

  // Reference model, written from the requirements.
  logic [W-1:0] m_arr [D];
  bit           m_known [D];
  logic [W-1:0] m_tos, m_nos;
  bit           m_tk, m_nk, m_busy;
  int           m_ptr;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    if (m_tk) chk(req, "tos", tos_o, m_tos);
    if (m_nk) chk(req, "nos", nos_o, m_nos);
    chk(req, "busy", {31'd0, busy_o}, {31'd0, m_busy});
  endtask

  task automatic model_step(input logic [2:0] c, input logic [W-1:0] v);
    if (m_busy) begin
      m_busy = 1'b0;
      return;
    end
    case (c)
      3'd1: begin
        m_ptr = (m_ptr + 1) % D;
        m_arr[m_ptr] = m_nos; m_known[m_ptr] = m_nk;
        m_nos = m_tos; m_nk = m_tk;
        m_tos = v; m_tk = 1'b1;
      end
      3'd2, 3'd4: begin
        m_tos = (c == 3'd4) ? v : m_nos;
        m_tk  = (c == 3'd4) ? 1'b1 : m_nk;
        m_nos = m_arr[m_ptr]; m_nk = m_known[m_ptr];
        m_ptr = (m_ptr + D - 1) % D;
      end
      3'd3: begin m_tos = v; m_tk = 1'b1; end
      default: ;
    endcase
    m_busy = (c == 3'd4);
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic apply(input string req, input logic [2:0] c, input logic [W-1:0] v);
    cmd_i = c;
    wdata_i = v;
    @(negedge clk);
    cmd_i = 3'd0;
    model_step(c, v);
    check_state(req);
  endtask

  task automatic t_reset;
    chk("R1", "tos", tos_o, '0);
    chk("R1", "nos", nos_o, '0);
    chk("R1", "busy", {31'd0, busy_o}, '0);
  endtask

  task automatic t_push_pop;
    apply("R3", 3'd1, 32'h1111_0001);
    apply("R3", 3'd1, 32'h1111_0002);
    apply("R3", 3'd1, 32'h1111_0003);
    apply("R4", 3'd2, 32'hdead_beef);
    apply("R4", 3'd2, 32'h0);
  endtask

  task automatic t_replace;
    apply("R5", 3'd1, 32'h2222_0001);
    apply("R5", 3'd3, 32'h2222_00aa);
    apply("R5", 3'd2, 32'h0);
  endtask

  task automatic t_idle_codes;
    apply("R2", 3'd1, 32'h3333_0001);
    for (int c = 5; c < 8; c++) apply("R2", 3'(c), 32'hffff_ffff);
    apply("R2", 3'd0, 32'h1234_5678);
  endtask

  task automatic t_binop;
    apply("R6", 3'd1, 32'h4444_0001);
    apply("R6", 3'd1, 32'h4444_0002);
    apply("R6", 3'd1, 32'h4444_0003);
    apply("R6", 3'd4, 32'h4444_00bb);
    apply("R7", 3'd0, 32'h0);
    chk("R7", "busy after wait", {31'd0, busy_o}, '0);
  endtask

  task automatic t_busy_ignore;
    apply("R7", 3'd1, 32'h5555_0001);
    apply("R7", 3'd4, 32'h5555_00cc);
    apply("R7", 3'd1, 32'h5555_0bad);
    apply("R7", 3'd3, 32'h5555_0099);
    apply("R7", 3'd4, 32'h5555_00dd);
    apply("R7", 3'd2, 32'h0);
    apply("R7", 3'd2, 32'h0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 12; i++) apply("R8", 3'd1, 32'h6000_0000 + 32'(i));
    for (int i = 0; i < 11; i++) apply("R8", 3'd2, 32'h0);
  endtask

  task automatic t_mixed;
    logic [15:0] lfsr = 16'hace1;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = (lfsr[2:0] > 3'd4) ? 3'd1 : lfsr[2:0];
      apply("R9", c, {lfsr, lfsr ^ 16'h5a5a});
    end
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin m_arr[i] = '0; m_known[i] = 1'b0; end
    m_tos = '0; m_nos = '0; m_tk = 1'b1; m_nk = 1'b1; m_busy = 1'b0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_replace();
    t_idle_codes();
    t_binop();
    t_busy_ignore();
    t_wrap();
    t_mixed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule